// File: doc/BRIEF.md
# Loop Counter Branch Unit

This unit carries out the three counted-loop branch primitives of a small processor core: count down and branch, count up and branch, and test and branch. A single control byte says which primitive to run, which of eight registers it works on, whether the branch follows a zero or a nonzero count, and whether the displacement points backward. A second byte carries the low eight bits of the displacement.

On a start strobe, the unit reads the selected register through a register-file read port. It adds the step (minus one, zero or plus one) and tests the stepped value for zero. One cycle later it presents three results: the branch decision, the branch target, and a writeback of the stepped value with its register index, all qualified by a done pulse. The program-counter input is the address that follows both bytes of the instruction. Fetch and pipeline flush are handled around the unit.

Top module: `loopbr_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the next outputs are done, illegal, taken and wb_en at 0 and target and wb_data at 0.
- R2: A start sampled high at a rising edge gives done high for the following cycle. With start low, done is low the following cycle. Back-to-back starts give back-to-back done pulses, each carrying its own result.
- R3: Control byte bits 7:6 pick the step: 00 subtracts one, 01 adds zero, 10 adds one. wb_idx carries bits 2:0 of the control byte.
- R4: rd_idx equals control byte bits 2:0 combinationally. Register indices 0, 1 and 2 are byte-wide: only rd_data bits 7:0 are used, the step wraps within 8 bits, the zero test covers those 8 bits, and wb_data bits 15:8 are 0. Indices 3 to 7 are 16 bits wide.
- R5: With control byte bit 5 at 1, taken is 1 when the stepped value is nonzero. With bit 5 at 0, taken is 1 when the stepped value is zero. taken is only high together with done.
- R6: target equals pc_next plus a 9-bit signed offset, modulo 2^16. The offset's sign is control byte bit 4 and its low 8 bits are disp.
- R7: On a legal control byte, wb_en is 1 with done, whether or not the branch is taken.
- R8: Control byte bits 7:6 equal to 11 give illegal high with done, with wb_en and taken both 0.
- R9: The add-zero form still writes back, and the value it writes back equals the register value it read.
- R10: On 16-bit registers the count wraps: 0x0000 minus one is 0xFFFF, and 0xFFFF plus one is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one loop-branch operation |
| postbyte | input | 8 | Control byte: step, polarity, offset sign, register |
| disp | input | 8 | Low 8 bits of the branch displacement |
| pc_next | input | 16 | Address following the two instruction bytes |
| rd_idx | output | 3 | Register-file read select |
| rd_data | input | 16 | Register-file read data |
| done | output | 1 | Result valid, one cycle after start |
| illegal | output | 1 | Control byte used the reserved step code |
| taken | output | 1 | Branch decision |
| target | output | 16 | Branch target address |
| wb_en | output | 1 | Register writeback strobe |
| wb_idx | output | 3 | Register index to write |
| wb_data | output | 16 | Stepped value to write |

## Verification
The assertions check four relations on every cycle. Start is always followed by done and idle cycles by none. A reserved step code never writes back or branches, and taken never appears without done. Byte-wide writebacks keep a clear upper byte, and the add-zero form on wide registers returns the value it read. The numeric results need the bench's scenarios: the zero test under each polarity, byte and word wrap-around, and forward and backward targets, including a target that wraps below address zero.

// File: rtl/loopbr_pkg.sv
// Package: shared encodings for the loop counter branch unit.
// Assumes an 8-bit control byte with fixed field positions.
package loopbr_pkg;
    localparam int PB_W  = 8;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        STEP_DEC = 2'b00,
        STEP_TST = 2'b01,
        STEP_INC = 2'b10,
        STEP_BAD = 2'b11
    } step_op_e;

    typedef struct packed {
        step_op_e             op;
        logic                 on_nonzero;
        logic                 back;
        logic [SEL_W-1:0]     sel;
    } ctrl_t;
endpackage

// File: rtl/loopbr_decode.sv
// Module: splits the control byte into step code, branch polarity,
// displacement sign and register select, and flags the reserved code.
// Assumes field positions 7:6, 5, 4 and 2:0; bit 3 is unused.
module loopbr_decode
    import loopbr_pkg::*;
(
    input  logic [PB_W-1:0] pb,
    output ctrl_t           ctrl,
    output logic            legal
);
    // Field extraction and reserved-code detection.
    always_comb begin
        ctrl.op         = step_op_e'(pb[7:6]);
        ctrl.on_nonzero = pb[5];
        ctrl.back       = pb[4];
        ctrl.sel        = pb[SEL_W-1:0];
        legal           = (pb[7:6] != 2'b11);
    end
endmodule

// File: rtl/loopbr_step.sv
// Module: applies the step to the operand and tests the result for zero.
// Assumes register indices below NARROW_REGS hold NARROW_W-bit values
// that wrap within their own width; the rest use the full DATA_W.
module loopbr_step
    import loopbr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int NARROW_REGS = 3
) (
    input  step_op_e          op,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              is_zero
);
    localparam int PAD_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] step_v;
    logic [DATA_W-1:0] wide_sum;
    logic              narrow;

    // Step constant chosen by the operation code.
    always_comb begin
        case (op)
            STEP_DEC: step_v = '1;
            STEP_INC: step_v = DATA_W'(1);
            default:  step_v = '0;
        endcase
    end

    assign wide_sum = operand + step_v;

    generate
        if (NARROW_REGS > 0) begin : g_narrow
            localparam logic [SEL_W-1:0] NLIM = SEL_W'(NARROW_REGS);
            logic [NARROW_W-1:0] narrow_sum;
            assign narrow     = (sel < NLIM);
            assign narrow_sum = operand[NARROW_W-1:0] + step_v[NARROW_W-1:0];
            // Width-dependent result selection.
            always_comb begin
                if (narrow) result = {{PAD_W{1'b0}}, narrow_sum};
                else        result = wide_sum;
            end
        end else begin : g_wide
            assign narrow = 1'b0;
            assign result = wide_sum;
        end
    endgenerate

    assign is_zero = (result == '0);
endmodule

// File: rtl/loopbr_target.sv
// Module: forms the branch target from the next PC and a signed offset
// whose sign bit comes from the control byte. Wraps modulo 2^ADDR_W.
module loopbr_target #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic              back,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] offset;

    assign offset = {{EXT_W{back}}, disp};
    assign target = pc + offset;
endmodule

// File: rtl/loopbr_unit.sv
// Module: loop counter branch unit top. Reads the selected register
// combinationally, computes step, zero test and target in the start
// cycle, and registers all results for one done cycle.
// Assumes rd_data reflects rd_idx within the same cycle.
module loopbr_unit
    import loopbr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 16,
    parameter int DISP_W      = 8,
    parameter int NARROW_W    = 8,
    parameter int NARROW_REGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        postbyte,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] pc_next,
    output logic [2:0]        rd_idx,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              illegal,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic              wb_en,
    output logic [2:0]        wb_idx,
    output logic [DATA_W-1:0] wb_data
);
    localparam logic [SEL_W-1:0] NLIM = SEL_W'(NARROW_REGS);

    ctrl_t             ctrl;
    logic              legal;
    logic [DATA_W-1:0] stepped;
    logic              stepped_zero;
    logic [ADDR_W-1:0] tgt_c;
    logic              branch_c;

    loopbr_decode u_dec (
        .pb    (postbyte),
        .ctrl  (ctrl),
        .legal (legal)
    );

    loopbr_step #(
        .DATA_W      (DATA_W),
        .NARROW_W    (NARROW_W),
        .NARROW_REGS (NARROW_REGS)
    ) u_step (
        .op      (ctrl.op),
        .sel     (ctrl.sel),
        .operand (rd_data),
        .result  (stepped),
        .is_zero (stepped_zero)
    );

    loopbr_target #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_tgt (
        .pc     (pc_next),
        .disp   (disp),
        .back   (ctrl.back),
        .target (tgt_c)
    );

    assign rd_idx   = ctrl.sel;
    assign branch_c = legal && (ctrl.on_nonzero ? !stepped_zero : stepped_zero);

    // Result register stage: pulses for one cycle, data held until next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            illegal <= 1'b0;
            taken   <= 1'b0;
            wb_en   <= 1'b0;
            target  <= '0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            done    <= start;
            illegal <= start && !legal;
            taken   <= start && branch_c;
            wb_en   <= start && legal;
            if (start) begin
                target <= tgt_c;
                wb_idx <= ctrl.sel;
                if (legal) wb_data <= stepped;
            end
        end
    end

    // R2: every start yields done on the next cycle
    assert_start_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R2: no done without a preceding start
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R8: reserved code blocks writeback and branch
    assert_illegal_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wb_en && !taken));
    // R5: branch decision only alongside done
    assert_taken_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> done);
    // R7: legal start always writes back
    assert_legal_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && postbyte[7:6] != 2'b11) |=> wb_en);
    // R4: byte-wide writebacks keep upper byte clear
    assert_byte_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_idx < NLIM) |-> (wb_data[DATA_W-1:NARROW_W] == '0));
    // R9: add-zero on a wide register returns the value read
    assert_test_unchanged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && postbyte[7:6] == 2'b01 && rd_idx >= NLIM) |=> (wb_data == $past(rd_data)));
endmodule

// File: tb/sim_loopbr_unit.sv
module sim_loopbr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = 8'h00;
    logic [7:0]  disp = 8'h00;
    logic [15:0] pc_next = 16'h0000;
    logic [2:0]  rd_idx;
    logic [15:0] rd_data;
    logic        done, illegal, taken, wb_en;
    logic [15:0] target, wb_data;
    logic [2:0]  wb_idx;

    logic [15:0] regfile [8];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign rd_data = regfile[rd_idx];

    loopbr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .disp(disp), .pc_next(pc_next), .rd_idx(rd_idx), .rd_data(rd_data),
        .done(done), .illegal(illegal), .taken(taken), .target(target),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    typedef struct packed {
        logic [7:0]  pb;
        logic [7:0]  dsp;
        logic [15:0] pc;
        logic [15:0] src;
        logic        e_taken;
        logic [15:0] e_tgt;
        logic [15:0] e_wb;
        logic        e_ill;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 8'h10, 16'h1000, 16'h0001, 1'b1, 16'h1010, 16'h0000, 1'b0}, // R3 R5 dec to zero
        '{8'h24, 8'h10, 16'h1000, 16'h0001, 1'b0, 16'h1010, 16'h0000, 1'b0}, // R5 R7 not taken
        '{8'h35, 8'hF0, 16'h2000, 16'h0005, 1'b1, 16'h1FF0, 16'h0004, 1'b0}, // R6 backward
        '{8'h86, 8'h02, 16'h3000, 16'hFFFF, 1'b1, 16'h3002, 16'h0000, 1'b0}, // R10 inc wrap
        '{8'hA7, 8'h80, 16'h4000, 16'h1234, 1'b1, 16'h4080, 16'h1235, 1'b0}, // R6 positive 0x80
        '{8'hB7, 8'h80, 16'h4000, 16'h1234, 1'b1, 16'h3F80, 16'h1235, 1'b0}, // R6 negative 0x80
        '{8'h43, 8'h20, 16'h0100, 16'h0000, 1'b1, 16'h0120, 16'h0000, 1'b0}, // R9 test zero
        '{8'h63, 8'h20, 16'h0100, 16'h0000, 1'b0, 16'h0120, 16'h0000, 1'b0}, // R9 R5
        '{8'h00, 8'h00, 16'h0500, 16'h0000, 1'b0, 16'h0500, 16'h00FF, 1'b0}, // R4 byte dec wrap
        '{8'hA1, 8'h05, 16'h0600, 16'h00FF, 1'b0, 16'h0605, 16'h0000, 1'b0}, // R4 byte inc wrap
        '{8'h82, 8'h01, 16'h0700, 16'hAB12, 1'b0, 16'h0701, 16'h0013, 1'b0}, // R4 upper ignored
        '{8'hC4, 8'h10, 16'h1000, 16'h0005, 1'b0, 16'h1010, 16'h0000, 1'b1}, // R8 illegal
        '{8'h14, 8'hFF, 16'h0000, 16'h0001, 1'b1, 16'hFFFF, 16'h0000, 1'b0}, // R6 wrap below zero
        '{8'h04, 8'h00, 16'h8000, 16'h0000, 1'b0, 16'h8000, 16'hFFFF, 1'b0}, // R10 dec wrap
        '{8'h45, 8'h03, 16'h0010, 16'h7777, 1'b0, 16'h0013, 16'h7777, 1'b0}  // R9 unchanged
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, raise start for one cycle.
    task automatic apply(input vec_t v);
        regfile[v.pb[2:0]] = v.src;
        postbyte = v.pb;
        disp     = v.dsp;
        pc_next  = v.pc;
        start    = 1'b1;
        #1;
        chk("R4 rd_idx", 32'(rd_idx), 32'(v.pb[2:0]));
    endtask

    task automatic check_result(input vec_t v);
        chk("R2 done", 32'(done), 32'd1);
        chk("R8 illegal", 32'(illegal), 32'(v.e_ill));
        chk("R7 wb_en", 32'(wb_en), 32'(!v.e_ill));
        chk("R5 taken", 32'(taken), 32'(v.e_taken));
        if (!v.e_ill) begin
            chk("R3 wb_idx", 32'(wb_idx), 32'(v.pb[2:0]));
            chk("R3 wb_data", 32'(wb_data), 32'(v.e_wb));
            chk("R6 target", 32'(target), 32'(v.e_tgt));
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regfile[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 done", 32'(done), 0);
        chk("R1 illegal", 32'(illegal), 0);
        chk("R1 taken", 32'(taken), 0);
        chk("R1 wb_en", 32'(wb_en), 0);
        chk("R1 target", 32'(target), 0);
        chk("R1 wb_data", 32'(wb_data), 0);
        // R1: start under reset has no effect
        apply(VECS[0]);
        @(negedge clk);
        chk("R1 done under reset", 32'(done), 0);
        chk("R1 wb_en under reset", 32'(wb_en), 0);
        start = 1'b0;
        rst_n = 1'b1;
        // R2: idle produces no done
        repeat (3) @(negedge clk);
        chk("R2 idle done", 32'(done), 0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            apply(VECS[k]);
            @(negedge clk);
            start = 1'b0;
            check_result(VECS[k]);
            @(negedge clk);
            chk("R2 done drops", 32'(done), 0);
            chk("R5 taken drops", 32'(taken), 0);
        end

        // R2: back-to-back starts
        apply(VECS[2]);
        @(negedge clk);
        check_result(VECS[2]);
        apply(VECS[9]);
        @(negedge clk);
        start = 1'b0;
        check_result(VECS[9]);
        @(negedge clk);
        chk("R2 done after pair", 32'(done), 0);

        // R8: illegal keeps previous writeback data on the port
        apply(VECS[4]);
        @(negedge clk);
        start = 1'b0;
        apply(VECS[11]);
        @(negedge clk);
        start = 1'b0;
        chk("R8 illegal", 32'(illegal), 1);
        chk("R8 wb_en", 32'(wb_en), 0);
        chk("R8 wb_data held", 32'(wb_data), 32'h1235);

        // R1: reset clears held results
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 target cleared", 32'(target), 0);
        chk("R1 wb_data cleared", 32'(wb_data), 0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule